// File: doc/BRIEF.md
# Indexed Palette DAC Port Interface

This block is the host side of a colour lookup table for a display pipeline. A host reaches it through a byte-wide strobed register interface with six port selects. Two index ports choose the entry that the next reads and the next writes will reach. A data port moves colour bytes in red, green, blue order, and the index steps on after each complete triplet, so a whole table can be streamed after one index write. A port shared between a pixel mask and a DAC command register completes the set. A pair of extended ports, one for the index and one for the data, reaches a sprite control register.

One bit of sprite control, the DAC-select bit, changes how the ports behave. While it is set, data-port traffic goes to a two-entry cursor palette and the index never advances. The shared port then reaches the command register in place of the pixel mask. The other sprite-control bits drive cursor-visible, large-cursor and coprocessor-reset outputs.

The video side gives a pixel index to a lookup port. The block masks that index with the pixel mask and returns the 24-bit colour one clock later.

Top module: `dacp_palette_port`

## Requirements
- R1: After reset the pixel mask reads 0xFF, the command register reads 0x00, sprite control reads 0x00, and both index ports read 0. The cursor_visible, cursor_large and cop_reset outputs are low.
- R2: Port selects are 0 mask/command, 1 read index, 2 write index, 3 data, 4 extended index, 5 extended data. After a write-index write, three data-port writes store red, green, blue into that entry, and pix_rgb packs them as {red[23:16], green[15:8], blue[7:0]}.
- R3: After the blue byte of an entry, the write index or read index in use advances by one and wraps from 255 to 0. Consecutive entries then stream without a new index write.
- R4: After a read-index write, data-port reads return the entry's red, green, blue bytes in turn. bus_rdata holds each result from the clock edge that samples bus_rd, and it is then stable until the next read.
- R5: A write to either index port restarts both component counters at red, so any partial triplet is discarded.
- R6: Red and green bytes are staged, and the table entry is left unchanged until the blue byte arrives.
- R7: Port 0 reaches the pixel mask while sprite-control bit 2 is clear and the command register while it is set. Each keeps its own value.
- R8: While sprite-control bit 2 is set, data-port triplets go to the cursor palette entry chosen by bit 0 of the index, the index does not advance, and the main table is not touched.
- R9: Sprite control is reached when the extended index equals 0x56. Writes to extended data under any other index are ignored, and reads return 0. Bits 0, 1 and 3 of sprite control drive cursor_visible, cursor_large and cop_reset.
- R10: pix_rgb is the table entry at (pix_idx AND pixel mask), registered one clock after pix_idx is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_wr | input | 1 | Write strobe for one byte access |
| bus_rd | input | 1 | Read strobe for one byte access |
| bus_port | input | 3 | Port select for the access |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Registered read byte |
| pix_idx | input | 8 | Pixel index to look up |
| pix_rgb | output | 24 | Colour for the previous cycle's masked pixel index |
| cursor_visible | output | 1 | Sprite-control bit 0 |
| cursor_large | output | 1 | Sprite-control bit 1 |
| cop_reset | output | 1 | Sprite-control bit 3 |

## Verification
The assertions assume the host never raises bus_wr and bus_rd in the same cycle. The stimulus keeps to this because every access goes through one task that drives a single strobe for one cycle and then drops it. The assertions also assume a lookup of an entry is not made in the same cycle that the entry is committed. The bench keeps to this by placing lookups only after the writing access has finished. The random phase picks whole triplet writes, triplet reads and masked lookups, and it runs with the DAC-select bit clear. The cursor palette is covered by directed cases.

// File: rtl/dacp_pkg.sv
package dacp_pkg;
  typedef enum logic [2:0] {
    PORT_MASK  = 3'd0,
    PORT_RIDX  = 3'd1,
    PORT_WIDX  = 3'd2,
    PORT_DATA  = 3'd3,
    PORT_XIDX  = 3'd4,
    PORT_XDATA = 3'd5
  } port_e;

  localparam logic [1:0] COMP_RED   = 2'd0;
  localparam logic [1:0] COMP_GREEN = 2'd1;
  localparam logic [1:0] COMP_BLUE  = 2'd2;
endpackage

// File: rtl/dacp_seq.sv
module dacp_seq #(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [IDX_W-1:0] load_val,
  input  logic             clear,
  input  logic             step,
  input  logic             hold,
  output logic [IDX_W-1:0] idx,
  output logic [1:0]       comp
);
  import dacp_pkg::*;

  logic [IDX_W-1:0] idx_n;
  logic [1:0]       comp_n;
  logic             at_blue;

  assign at_blue = (comp == COMP_BLUE);

  always_comb begin
    comp_n = comp;
    idx_n  = idx;
    if (clear) begin
      comp_n = COMP_RED;
    end else if (step) begin
      comp_n = at_blue ? COMP_RED : comp + 2'd1;
    end
    if (load) begin
      idx_n = load_val;
    end else if (step && at_blue && !hold) begin
      idx_n = idx + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx  <= '0;
      comp <= COMP_RED;
    end else begin
      idx  <= idx_n;
      comp <= comp_n;
    end
  end

  AST_COMP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    comp != 2'd3); // R2
  AST_IDX_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && !clear && !hold && comp == COMP_BLUE) |=> idx == $past(idx) + 1'b1); // R3
  AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (step && hold && !load) |=> $stable(idx)); // R8
  AST_CLEAR_COMP: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> comp == COMP_RED); // R5
endmodule

// File: rtl/dacp_lut.sv
module dacp_lut #(
  parameter int IDX_W  = 8,
  parameter int COMP_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [IDX_W-1:0]    waddr,
  input  logic [3*COMP_W-1:0] wdata,
  input  logic [IDX_W-1:0]    haddr,
  output logic [3*COMP_W-1:0] hdata,
  input  logic [IDX_W-1:0]    look_idx,
  output logic [3*COMP_W-1:0] look_rgb
);
  localparam int DEPTH = 1 << IDX_W;

  logic [3*COMP_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign hdata = mem[haddr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      look_rgb <= '0;
    end else begin
      look_rgb <= mem[look_idx];
    end
  end
endmodule

// File: rtl/dacp_palette_port.sv
module dacp_palette_port #(
  parameter int          IDX_W    = 8,
  parameter int          COMP_W   = 8,
  parameter logic [7:0]  XCTL_IDX = 8'h56
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [2:0]          bus_port,
  input  logic [COMP_W-1:0]   bus_wdata,
  output logic [COMP_W-1:0]   bus_rdata,
  input  logic [IDX_W-1:0]    pix_idx,
  output logic [3*COMP_W-1:0] pix_rgb,
  output logic                cursor_visible,
  output logic                cursor_large,
  output logic                cop_reset
);
  import dacp_pkg::*;

  localparam int RGB_W = 3 * COMP_W;
  localparam int SEL_BIT = 2;

  logic [1:0] rst_sync;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_s = rst_sync[1];

  logic [COMP_W-1:0] mask_q, cmd_q, xidx_q, spr_q;
  logic [COMP_W-1:0] mask_n, cmd_n, xidx_n, spr_n;
  logic [COMP_W-1:0] stage_r, stage_g, stage_r_n, stage_g_n;
  logic [COMP_W-1:0] rdata_n;
  logic [RGB_W-1:0]  cur_pal [2];
  logic              sel;

  logic wr_mask, wr_ridx, wr_widx, wr_data, wr_xidx, wr_xdata, rd_data, idx_wr;
  assign wr_mask  = bus_wr && (bus_port == PORT_MASK);
  assign wr_ridx  = bus_wr && (bus_port == PORT_RIDX);
  assign wr_widx  = bus_wr && (bus_port == PORT_WIDX);
  assign wr_data  = bus_wr && (bus_port == PORT_DATA);
  assign wr_xidx  = bus_wr && (bus_port == PORT_XIDX);
  assign wr_xdata = bus_wr && (bus_port == PORT_XDATA);
  assign rd_data  = bus_rd && (bus_port == PORT_DATA);
  assign idx_wr   = wr_ridx || wr_widx;
  assign sel      = spr_q[SEL_BIT];

  logic [IDX_W-1:0] widx, ridx;
  logic [1:0]       wcomp, rcomp;

  dacp_seq #(.IDX_W(IDX_W)) u_wseq (
    .clk(clk), .rst_n(rst_n_s), .load(wr_widx), .load_val(bus_wdata[IDX_W-1:0]),
    .clear(idx_wr), .step(wr_data), .hold(sel), .idx(widx), .comp(wcomp)
  );

  dacp_seq #(.IDX_W(IDX_W)) u_rseq (
    .clk(clk), .rst_n(rst_n_s), .load(wr_ridx), .load_val(bus_wdata[IDX_W-1:0]),
    .clear(idx_wr), .step(rd_data), .hold(sel), .idx(ridx), .comp(rcomp)
  );

  logic              commit;
  logic [RGB_W-1:0]  commit_rgb;
  logic [RGB_W-1:0]  host_rgb, rd_word;
  logic [IDX_W-1:0]  look_idx;

  assign commit     = wr_data && (wcomp == COMP_BLUE);
  assign commit_rgb = {stage_r, stage_g, bus_wdata};
  assign look_idx   = pix_idx & mask_q[IDX_W-1:0];

  dacp_lut #(.IDX_W(IDX_W), .COMP_W(COMP_W)) u_lut (
    .clk(clk), .rst_n(rst_n_s), .we(commit && !sel), .waddr(widx),
    .wdata(commit_rgb), .haddr(ridx), .hdata(host_rgb),
    .look_idx(look_idx), .look_rgb(pix_rgb)
  );

  always_ff @(posedge clk) begin
    if (commit && sel) begin
      cur_pal[widx[0]] <= commit_rgb;
    end
  end

  assign rd_word = sel ? cur_pal[ridx[0]] : host_rgb;

  always_comb begin
    mask_n    = mask_q;
    cmd_n     = cmd_q;
    xidx_n    = xidx_q;
    spr_n     = spr_q;
    stage_r_n = stage_r;
    stage_g_n = stage_g;
    if (wr_mask && !sel) mask_n = bus_wdata;
    if (wr_mask && sel)  cmd_n  = bus_wdata;
    if (wr_xidx)         xidx_n = bus_wdata;
    if (wr_xdata && (xidx_q == XCTL_IDX)) spr_n = bus_wdata;
    if (wr_data && (wcomp == COMP_RED))   stage_r_n = bus_wdata;
    if (wr_data && (wcomp == COMP_GREEN)) stage_g_n = bus_wdata;
  end

  always_comb begin
    rdata_n = '0;
    case (bus_port)
      PORT_MASK:  rdata_n = sel ? cmd_q : mask_q;
      PORT_RIDX:  rdata_n = COMP_W'(ridx);
      PORT_WIDX:  rdata_n = COMP_W'(widx);
      PORT_DATA: begin
        case (rcomp)
          COMP_RED:   rdata_n = rd_word[2*COMP_W +: COMP_W];
          COMP_GREEN: rdata_n = rd_word[COMP_W +: COMP_W];
          default:    rdata_n = rd_word[0 +: COMP_W];
        endcase
      end
      PORT_XIDX:  rdata_n = xidx_q;
      PORT_XDATA: rdata_n = (xidx_q == XCTL_IDX) ? spr_q : '0;
      default:    rdata_n = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      mask_q    <= '1;
      cmd_q     <= '0;
      xidx_q    <= '0;
      spr_q     <= '0;
      stage_r   <= '0;
      stage_g   <= '0;
      bus_rdata <= '0;
    end else begin
      mask_q    <= mask_n;
      cmd_q     <= cmd_n;
      xidx_q    <= xidx_n;
      spr_q     <= spr_n;
      stage_r   <= stage_r_n;
      stage_g   <= stage_g_n;
      if (bus_rd) bus_rdata <= rdata_n;
    end
  end

  assign cursor_visible = spr_q[0];
  assign cursor_large   = spr_q[1];
  assign cop_reset      = spr_q[3];

  AST_NO_RW_COLLIDE: assert property (@(posedge clk) disable iff (!rst_n_s)
    !(bus_wr && bus_rd)); // R4
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n_s)
    !bus_rd |=> $stable(bus_rdata)); // R4
  AST_XDATA_GUARD: assert property (@(posedge clk) disable iff (!rst_n_s)
    (wr_xdata && xidx_q != XCTL_IDX) |=> $stable(spr_q)); // R9
  AST_MASK_KEPT_SEL: assert property (@(posedge clk) disable iff (!rst_n_s)
    (wr_mask && sel) |=> $stable(mask_q)); // R7
  AST_CMD_KEPT_NOSEL: assert property (@(posedge clk) disable iff (!rst_n_s)
    (wr_mask && !sel) |=> $stable(cmd_q)); // R7
endmodule

// File: tb/sim_dacp_palette_port.sv
module sim_dacp_palette_port;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [2:0]  bus_port = 3'd0;
  logic [7:0]  bus_wdata = 8'd0;
  logic [7:0]  bus_rdata;
  logic [7:0]  pix_idx = 8'd0;
  logic [23:0] pix_rgb;
  logic        cursor_visible, cursor_large, cop_reset;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [23:0] ref_pal [256];
  logic [23:0] ref_cur [2];
  logic [7:0]  ref_mask;

  always #(CLK_P/2) clk = ~clk;

  dacp_palette_port u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_port(bus_port),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pix_idx(pix_idx), .pix_rgb(pix_rgb),
    .cursor_visible(cursor_visible), .cursor_large(cursor_large), .cop_reset(cop_reset)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bwr(input logic [2:0] p, input logic [7:0] d);
    @(negedge clk);
    bus_port = p; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic brd(input logic [2:0] p, output logic [7:0] d);
    @(negedge clk);
    bus_port = p; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic wtrip(input logic [23:0] c);
    bwr(3'd3, c[23:16]); bwr(3'd3, c[15:8]); bwr(3'd3, c[7:0]);
  endtask

  task automatic rtrip(output logic [23:0] c);
    logic [7:0] b;
    brd(3'd3, b); c[23:16] = b;
    brd(3'd3, b); c[15:8] = b;
    brd(3'd3, b); c[7:0] = b;
  endtask

  task automatic look(input logic [7:0] p, output logic [23:0] c);
    @(negedge clk);
    pix_idx = p;
    @(negedge clk);
    c = pix_rgb;
  endtask

  function automatic logic [23:0] exp_look(input logic [7:0] p);
    return ref_pal[p & ref_mask];
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0]  b;
    logic [23:0] c, c2;
    void'($urandom(32'd2024));
    ref_mask = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk({29'd0, cursor_visible, cursor_large, cop_reset}, 32'd0, "R1 outputs");
    brd(3'd0, b); chk(b, 8'hFF, "R1 mask");
    brd(3'd1, b); chk(b, 8'h00, "R1 ridx");
    brd(3'd2, b); chk(b, 8'h00, "R1 widx");
    brd(3'd5, b); chk(b, 8'h00, "R1 sprite ctl");

    // R2 R3 stream the whole table
    bwr(3'd2, 8'd0);
    for (int i = 0; i < 256; i++) begin
      ref_pal[i] = 24'($urandom);
      wtrip(ref_pal[i]);
    end
    brd(3'd2, b); chk(b, 8'd0, "R3 widx wrap");
    for (int i = 0; i < 8; i++) begin
      int p = (i * 37 + 3) % 256;
      look(8'(p), c); chk(c, exp_look(8'(p)), "R2 R10 lookup after stream");
    end
    look(8'd255, c); chk(c, ref_pal[255], "R3 last entry");

    // R4 read back with auto-increment
    bwr(3'd1, 8'd5);
    rtrip(c); chk(c, ref_pal[5], "R4 read entry 5");
    rtrip(c); chk(c, ref_pal[6], "R4 R3 read entry 6");
    brd(3'd1, b); chk(b, 8'd7, "R3 ridx advanced");
    bwr(3'd1, 8'd255);
    rtrip(c); chk(c, ref_pal[255], "R4 read entry 255");
    brd(3'd1, b); chk(b, 8'd0, "R3 ridx wrap");

    // R6 partial triplet not committed
    bwr(3'd2, 8'd10);
    bwr(3'd3, 8'hAA); bwr(3'd3, 8'hBB);
    look(8'd10, c); chk(c, ref_pal[10], "R6 entry unchanged by partial");
    // R5 index write discards partial triplet
    bwr(3'd2, 8'd10);
    ref_pal[10] = 24'h123456;
    wtrip(24'h123456);
    look(8'd10, c); chk(c, 24'h123456, "R5 restart at red");
    look(8'd11, c); chk(c, ref_pal[11], "R5 neighbour unchanged");
    // R5 read side: partial read then read-index write restarts at red
    bwr(3'd1, 8'd10);
    brd(3'd3, b);
    bwr(3'd1, 8'd10);
    rtrip(c); chk(c, 24'h123456, "R5 read restart");

    // R10 masking
    bwr(3'd0, 8'h0F); ref_mask = 8'h0F;
    look(8'h35, c); chk(c, ref_pal[5], "R10 masked lookup");
    brd(3'd0, b); chk(b, 8'h0F, "R7 mask readback");

    // R9 extended registers
    bwr(3'd4, 8'h12); bwr(3'd5, 8'hFF);
    chk({29'd0, cursor_visible, cursor_large, cop_reset}, 32'd0, "R9 other index ignored");
    brd(3'd5, b); chk(b, 8'h00, "R9 other index reads zero");
    bwr(3'd4, 8'h56); bwr(3'd5, 8'h0B);
    chk({29'd0, cursor_visible, cursor_large, cop_reset}, 32'd7, "R9 control bits");
    brd(3'd5, b); chk(b, 8'h0B, "R9 ctl readback");

    // R7 command register behind port 0 while selected
    bwr(3'd5, 8'h04);
    chk({29'd0, cursor_visible, cursor_large, cop_reset}, 32'd0, "R9 bits cleared");
    bwr(3'd0, 8'h5A);
    brd(3'd0, b); chk(b, 8'h5A, "R7 command readback");
    look(8'h35, c); chk(c, ref_pal[5], "R7 mask kept while selected");

    // R8 cursor palette
    bwr(3'd2, 8'd1);
    wtrip(24'h0A0B0C);
    wtrip(24'hC0FFEE); ref_cur[1] = 24'hC0FFEE;
    brd(3'd2, b); chk(b, 8'd1, "R8 no widx advance");
    bwr(3'd2, 8'd0);
    wtrip(24'h00FF00); ref_cur[0] = 24'h00FF00;
    bwr(3'd1, 8'd1);
    rtrip(c); chk(c, ref_cur[1], "R8 cursor 1 read");
    rtrip(c); chk(c, ref_cur[1], "R8 no ridx advance");
    bwr(3'd1, 8'd2);
    rtrip(c); chk(c, ref_cur[0], "R8 index bit 0 picks entry");

    bwr(3'd5, 8'h00);
    brd(3'd0, b); chk(b, 8'h0F, "R7 mask back");
    bwr(3'd0, 8'hFF); ref_mask = 8'hFF;
    bwr(3'd5, 8'h04);
    brd(3'd0, b); chk(b, 8'h5A, "R7 command kept");
    bwr(3'd5, 8'h00);
    look(8'd0, c); chk(c, ref_pal[0], "R8 main entry 0 untouched");
    look(8'd1, c); chk(c, ref_pal[1], "R8 main entry 1 untouched");
    look(8'd2, c); chk(c, ref_pal[2], "R8 main entry 2 untouched");

    // random phase
    for (int n = 0; n < 300; n++) begin
      int op = $urandom_range(0, 2);
      logic [7:0] a = 8'($urandom);
      if (op == 0) begin
        c2 = 24'($urandom);
        bwr(3'd2, a); wtrip(c2); ref_pal[a] = c2;
        look(a, c); chk(c, ref_pal[a & ref_mask], "R2 random write");
      end else if (op == 1) begin
        bwr(3'd1, a); rtrip(c); chk(c, ref_pal[a], "R4 random read");
      end else begin
        ref_mask = 8'($urandom);
        bwr(3'd0, ref_mask);
        look(a, c); chk(c, exp_look(a), "R10 random lookup");
      end
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule